// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block holds the control state a small processor uses to enter a handler at an instruction boundary and to return from it. Device controllers post requests into sticky per-device pending flags. An external signal line posts a request into its own sticky flag. The instruction datapath reports three things at the end of each instruction: that the instruction finished, the sequential next program counter, and whether the instruction was a trap (with a call number) or raised an error. When interrupts are enabled and something is pending at that boundary, the sequencer takes an entry in one step. It saves the program counter and the previous mode, forces privileged mode, masks interrupts, records a cause type and code, and redirects the program counter.

Device, error and external entries go to one common handler address. Trap entries are vectored through a 16-entry table of handler addresses indexed by the call number. Kernel code loads that table, and may also preload the saved context to launch a user program. A return command restores the saved mode and program counter and re-enables interrupts in the same step, so a request that is still pending is taken at the very next boundary.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `priv`=1, `ie`=0, `pc`=0, `epc`=0, `saved_priv`=1, `cause_type`=0, `cause_code`=0, `taken`=0, and every pending flag is 0.
- R2: A `dev_raise` bit sets the matching `dev_pend` bit on the next cycle. The bit stays set until a `dev_clr` bit for it is seen. A clear leaves the other bits alone. A raise and a clear of the same bit in one cycle leave it set.
- R3: At a boundary (`instr_done`=1) with `ie`=0, or with nothing pending, no entry happens: next cycle `pc` equals `next_pc` and `taken`=0.
- R4: An entry is visible one cycle after the boundary. `taken`=1, `priv`=1, `ie`=0, `epc` equals the boundary's `next_pc`, and `saved_priv` equals the mode before entry. Device, error and external entries load `pc` with `HANDLER_ADDR`.
- R5: `cause_type` encodes 0 = I/O completion, 1 = error, 2 = service request, 3 = external signal. `cause_code` is 0 for error and external entries.
- R6: Among pending devices the lowest index wins, and its index appears in `cause_code`. The entry does not clear any pending flag.
- R7: Priority at one boundary is trap, then error, then external, then device.
- R8: A trap entry loads `pc` with table entry `trap_num` and puts `trap_num` in `cause_code`.
- R9: A table write (`tbl_we`) takes effect only when `priv`=1. A write in user mode leaves the entry unchanged.
- R10: `rti` with `priv`=1 loads `pc` from `epc` and `priv` from `saved_priv`, and sets `ie`=1, all on the next cycle. `rti` with `priv`=0 changes nothing.
- R11: Once `rti` has set `ie`, a request still pending is taken at the next boundary.
- R12: `ctx_we` with `priv`=1 writes `epc` and `saved_priv` when no entry or return happens in that cycle. In user mode it has no effect.
- R13: `ext_raise` sets `ext_pend` and `ext_clr` clears it, with the same timing as the device flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_raise | input | N_DEV | Per-device request strobes |
| dev_clr | input | N_DEV | Software clear of device flags |
| ext_raise | input | 1 | External signal request strobe |
| ext_clr | input | 1 | Software clear of external flag |
| instr_done | input | 1 | Instruction boundary |
| next_pc | input | PC_W | Sequential next PC at the boundary |
| trap_req | input | 1 | Finishing instruction is a trap |
| trap_num | input | CALL_W | Trap call number |
| err_req | input | 1 | Finishing instruction raised an error |
| rti | input | 1 | Return-from-interrupt command |
| ctx_we | input | 1 | Write saved context |
| ctx_pc | input | PC_W | Saved PC to write |
| ctx_priv | input | 1 | Saved mode to write |
| tbl_we | input | 1 | Trap table write |
| tbl_idx | input | CALL_W | Trap table write index |
| tbl_data | input | PC_W | Trap table write data |
| pc | output | PC_W | Program counter |
| priv | output | 1 | 1 = privileged mode |
| ie | output | 1 | Interrupt enable |
| epc | output | PC_W | Saved PC |
| saved_priv | output | 1 | Saved mode |
| cause_type | output | 2 | Cause type of last entry |
| cause_code | output | CALL_W | Device index or call number |
| taken | output | 1 | One-cycle entry pulse |
| dev_pend | output | N_DEV | Device pending flags |
| ext_pend | output | 1 | External pending flag |

## Verification
A corrupted mode or enable bit shows up at the ports within one boundary. An entry that fails to mask interrupts, or a return that fails to restore user mode, shows at once on `priv`/`ie`, and at the next boundary as an entry that is taken or skipped wrongly. A wrong priority or lowest-index choice appears on `cause_type`/`cause_code` and on `pc` in the cycle right after the boundary. A trap table entry that was wrongly written stays hidden until a trap uses its call number, so the bench sweeps every call number through a trap and retries one after a user-mode write attempt.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [1:0] {
        CAUSE_IO  = 2'd0,
        CAUSE_ERR = 2'd1,
        CAUSE_SVC = 2'd2,
        CAUSE_EXT = 2'd3
    } cause_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raise,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        // raise beats clear on the same bit
        pend_d = (pend_q & ~clr) | raise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        // scan downwards so the lowest set index is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/trap_vec_table.sv
module trap_vec_table #(
    parameter int AW   = 4,
    parameter int DW   = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] tbl_d [DEPTH];
    logic [DW-1:0] tbl_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (we) tbl_d[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    assign rdata = tbl_q[ridx];
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int              N_DEV        = 4,
    parameter int              PC_W         = 16,
    parameter int              CALL_W       = 4,
    parameter logic [PC_W-1:0] HANDLER_ADDR = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DEV-1:0]  dev_raise,
    input  logic [N_DEV-1:0]  dev_clr,
    input  logic              ext_raise,
    input  logic              ext_clr,
    input  logic              instr_done,
    input  logic [PC_W-1:0]   next_pc,
    input  logic              trap_req,
    input  logic [CALL_W-1:0] trap_num,
    input  logic              err_req,
    input  logic              rti,
    input  logic              ctx_we,
    input  logic [PC_W-1:0]   ctx_pc,
    input  logic              ctx_priv,
    input  logic              tbl_we,
    input  logic [CALL_W-1:0] tbl_idx,
    input  logic [PC_W-1:0]   tbl_data,
    output logic [PC_W-1:0]   pc,
    output logic              priv,
    output logic              ie,
    output logic [PC_W-1:0]   epc,
    output logic              saved_priv,
    output logic [1:0]        cause_type,
    output logic [CALL_W-1:0] cause_code,
    output logic              taken,
    output logic [N_DEV-1:0]  dev_pend,
    output logic              ext_pend
);
    localparam int DEV_IW = (N_DEV > 1) ? $clog2(N_DEV) : 1;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              priv;
        logic              ie;
        logic [PC_W-1:0]   epc;
        logic              saved_priv;
        cause_e            ctype;
        logic [CALL_W-1:0] ccode;
        logic              taken;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic              dev_any;
    logic [DEV_IW-1:0] dev_idx;
    logic [PC_W-1:0]   trap_vec;
    logic              do_ret;
    logic              do_entry;

    irq_flag_bank #(.N(N_DEV)) u_dev_flags (
        .clk(clk), .rst_n(rst_n), .raise(dev_raise), .clr(dev_clr), .pend(dev_pend)
    );

    irq_flag_bank #(.N(1)) u_ext_flag (
        .clk(clk), .rst_n(rst_n), .raise(ext_raise), .clr(ext_clr), .pend(ext_pend)
    );

    irq_low_pick #(.N(N_DEV)) u_pick (
        .req(dev_pend), .any(dev_any), .idx(dev_idx)
    );

    trap_vec_table #(.AW(CALL_W), .DW(PC_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we && s_q.priv), .widx(tbl_idx), .wdata(tbl_data),
        .ridx(trap_num), .rdata(trap_vec)
    );

    always_comb begin
        s_d       = s_q;
        s_d.taken = 1'b0;
        do_ret    = rti && s_q.priv;
        do_entry  = !do_ret && instr_done && s_q.ie &&
                    (trap_req || err_req || ext_pend || dev_any);

        if (do_ret) begin
            s_d.pc   = s_q.epc;
            s_d.priv = s_q.saved_priv;
            s_d.ie   = 1'b1;
        end else if (do_entry) begin
            s_d.epc        = next_pc;
            s_d.saved_priv = s_q.priv;
            s_d.priv       = 1'b1;
            s_d.ie         = 1'b0;
            s_d.taken      = 1'b1;
            s_d.pc         = HANDLER_ADDR;
            s_d.ccode      = '0;
            if (trap_req) begin
                s_d.ctype = CAUSE_SVC;
                s_d.ccode = trap_num;
                s_d.pc    = trap_vec;
            end else if (err_req) begin
                s_d.ctype = CAUSE_ERR;
            end else if (ext_pend) begin
                s_d.ctype = CAUSE_EXT;
            end else begin
                s_d.ctype = CAUSE_IO;
                s_d.ccode = CALL_W'(dev_idx);
            end
        end else begin
            if (instr_done) s_d.pc = next_pc;
            if (ctx_we && s_q.priv) begin
                s_d.epc        = ctx_pc;
                s_d.saved_priv = ctx_priv;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pc         <= '0;
            s_q.priv       <= 1'b1;
            s_q.ie         <= 1'b0;
            s_q.epc        <= '0;
            s_q.saved_priv <= 1'b1;
            s_q.ctype      <= CAUSE_IO;
            s_q.ccode      <= '0;
            s_q.taken      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc         = s_q.pc;
    assign priv       = s_q.priv;
    assign ie         = s_q.ie;
    assign epc        = s_q.epc;
    assign saved_priv = s_q.saved_priv;
    assign cause_type = s_q.ctype;
    assign cause_code = s_q.ccode;
    assign taken      = s_q.taken;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int N_DEV = 4,
    parameter int PC_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DEV-1:0] dev_clr,
    input logic             instr_done,
    input logic [PC_W-1:0]  next_pc,
    input logic             trap_req,
    input logic             rti,
    input logic             priv,
    input logic             ie,
    input logic [PC_W-1:0]  epc,
    input logic [1:0]       cause_type,
    input logic             taken,
    input logic [N_DEV-1:0] dev_pend
);
    p_entry_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (priv && !ie));

    p_epc_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (epc == $past(next_pc)));

    p_entry_needs_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> $past(ie && instr_done));

    p_ie_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie) |-> $past(rti && priv));

    p_user_only_by_rti_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(priv) |-> $past(rti));

    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(dev_pend) & ~dev_pend) & ~$past(dev_clr)) == '0));

    p_trap_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(instr_done && ie && trap_req && !(rti && priv)) |->
            (taken && cause_type == 2'd2));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.N_DEV(N_DEV), .PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dev_clr(dev_clr), .instr_done(instr_done),
    .next_pc(next_pc), .trap_req(trap_req), .rti(rti), .priv(priv), .ie(ie),
    .epc(epc), .cause_type(cause_type), .taken(taken), .dev_pend(dev_pend)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
    localparam int N_DEV = 4;
    localparam int PC_W = 16;
    localparam int CALL_W = 4;
    localparam logic [15:0] HND = 16'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_DEV-1:0] dev_raise = '0, dev_clr = '0;
    logic ext_raise = 0, ext_clr = 0, instr_done = 0, trap_req = 0, err_req = 0;
    logic rti = 0, ctx_we = 0, ctx_priv = 0, tbl_we = 0;
    logic [PC_W-1:0] next_pc = '0, ctx_pc = '0, tbl_data = '0;
    logic [CALL_W-1:0] trap_num = '0, tbl_idx = '0;
    logic [PC_W-1:0] pc, epc;
    logic priv, ie, saved_priv, taken, ext_pend;
    logic [1:0] cause_type;
    logic [CALL_W-1:0] cause_code;
    logic [N_DEV-1:0] dev_pend;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_entry_seq #(.N_DEV(N_DEV), .PC_W(PC_W), .CALL_W(CALL_W), .HANDLER_ADDR(HND)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_raise(dev_raise), .dev_clr(dev_clr),
        .ext_raise(ext_raise), .ext_clr(ext_clr), .instr_done(instr_done),
        .next_pc(next_pc), .trap_req(trap_req), .trap_num(trap_num), .err_req(err_req),
        .rti(rti), .ctx_we(ctx_we), .ctx_pc(ctx_pc), .ctx_priv(ctx_priv),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .pc(pc), .priv(priv), .ie(ie), .epc(epc), .saved_priv(saved_priv),
        .cause_type(cause_type), .cause_code(cause_code), .taken(taken),
        .dev_pend(dev_pend), .ext_pend(ext_pend)
    );

    function automatic logic [15:0] vec_of(input int k);
        return 16'h1000 + 16'(k) * 16'h0111;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock; strobes dropped just after the edge
    task automatic cyc();
        @(posedge clk);
        #1;
        dev_raise = '0; dev_clr = '0; ext_raise = 0; ext_clr = 0;
        instr_done = 0; trap_req = 0; err_req = 0; rti = 0;
        ctx_we = 0; tbl_we = 0;
    endtask

    // from privileged mode: preload context and return into it
    task automatic launch(input logic [15:0] p, input logic m);
        ctx_we = 1; ctx_pc = p; ctx_priv = m;
        cyc();
        rti = 1;
        cyc();
    endtask

    task automatic boundary(input logic [15:0] npc, input logic t, input logic [3:0] tn,
                            input logic e);
        instr_done = 1; next_pc = npc; trap_req = t; trap_num = tn; err_req = e;
        cyc();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pc", 32'(pc), 0);
        chk("R1 priv", 32'(priv), 1);
        chk("R1 ie", 32'(ie), 0);
        chk("R1 pend", 32'({dev_pend, ext_pend}), 0);
        rst_n = 1;
        cyc();
        chk("R1 after release", 32'({priv, ie, saved_priv, taken, cause_type, cause_code}),
            32'({1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd0}));
        chk("R1 epc", 32'(epc), 0);

        // R3: boundary with ie=0 and a request pending
        dev_raise = 4'b0001;
        cyc();
        boundary(16'h1234, 1, 4'd2, 0);
        chk("R3 no entry pc", 32'(pc), 32'h1234);
        chk("R3 no entry taken", 32'(taken), 0);
        dev_clr = 4'b0001;
        cyc();

        // R9/R8: load table, sweep every call number
        for (int k = 0; k < 16; k++) begin
            tbl_we = 1; tbl_idx = 4'(k); tbl_data = vec_of(k);
            cyc();
        end
        for (int k = 0; k < 16; k++) begin
            launch(16'h0200 + 16'(k), 1);
            chk("R10 return ie", 32'(ie), 1);
            boundary(16'h0300 + 16'(k), 1, 4'(k), 0);
            chk("R8 trap pc", 32'(pc), 32'(vec_of(k)));
            chk("R8 trap code", 32'(cause_code), k);
            chk("R5 svc type", 32'(cause_type), 2);
            chk("R4 entry state", 32'({taken, priv, ie, saved_priv}), 32'(4'b1101));
            chk("R4 epc", 32'(epc), 32'(16'h0300 + 16'(k)));
        end

        // R3: enabled, nothing pending
        launch(16'h0020, 1);
        boundary(16'h2222, 0, 0, 0);
        chk("R3 idle pc", 32'(pc), 32'h2222);
        chk("R3 idle taken", 32'(taken), 0);

        // R2: clear semantics
        dev_raise = 4'b1111;
        cyc();
        chk("R2 raise", 32'(dev_pend), 32'hf);
        dev_clr = 4'b0101; dev_raise = 4'b0001;
        cyc();
        chk("R2 partial clear, raise wins", 32'(dev_pend), 32'b1011);
        dev_clr = 4'b1111;
        cyc();
        chk("R2 clear all", 32'(dev_pend), 0);

        // R6: lowest pending device wins, flags remain
        for (int m = 1; m < 16; m++) begin
            int low = 0;
            for (int b = 3; b >= 0; b--) if (m[b]) low = b;
            dev_raise = 4'(m);
            cyc();
            chk("R2 pend", 32'(dev_pend), m);
            launch(16'h0050, 1);
            boundary(16'h0051, 0, 0, 0);
            chk("R6 code", 32'(cause_code), low);
            chk("R5 io type", 32'(cause_type), 0);
            chk("R4 handler pc", 32'(pc), 32'(HND));
            chk("R6 flags kept", 32'(dev_pend), m);
            dev_clr = 4'hf;
            cyc();
        end

        // R13: external flag
        ext_raise = 1;
        cyc();
        chk("R13 ext set", 32'(ext_pend), 1);
        ext_clr = 1;
        cyc();
        chk("R13 ext clear", 32'(ext_pend), 0);

        // R7: priority over trap/error/external/device
        for (int c = 1; c < 16; c++) begin
            logic [1:0] et;
            logic [3:0] ec;
            logic [15:0] ep;
            if (c[1]) ext_raise = 1;
            if (c[0]) dev_raise = 4'b0100;
            cyc();
            launch(16'h0070, 1);
            boundary(16'h0071, c[3], 4'd5, c[2]);
            if (c[3]) begin et = 2; ec = 5; ep = vec_of(5); end
            else if (c[2]) begin et = 1; ec = 0; ep = HND; end
            else if (c[1]) begin et = 3; ec = 0; ep = HND; end
            else begin et = 0; ec = 2; ep = HND; end
            chk("R7 type", 32'(cause_type), 32'(et));
            chk("R7 code", 32'(cause_code), 32'(ec));
            chk("R7 pc", 32'(pc), 32'(ep));
            dev_clr = 4'hf; ext_clr = 1;
            cyc();
        end

        // R11: pending while masked, taken right after return
        dev_raise = 4'b1000;
        cyc();
        boundary(16'h0600, 0, 0, 0);
        chk("R11 masked", 32'(taken), 0);
        launch(16'h0700, 1);
        boundary(16'h0701, 0, 0, 0);
        chk("R11 taken after return", 32'({taken, cause_code}), 32'({1'b1, 4'd3}));
        dev_clr = 4'hf;
        cyc();

        // R9/R10/R12: user mode
        launch(16'h0400, 0);
        chk("R10 user entry", 32'({priv, ie, pc}), 32'({1'b0, 1'b1, 16'h0400}));
        tbl_we = 1; tbl_idx = 4'd3; tbl_data = 16'hdead;
        cyc();
        ctx_we = 1; ctx_pc = 16'h9999; ctx_priv = 1;
        cyc();
        chk("R12 user ctx ignored", 32'({saved_priv, epc}), 32'({1'b0, 16'h0400}));
        rti = 1;
        cyc();
        chk("R10 user rti ignored", 32'({priv, pc}), 32'({1'b0, 16'h0400}));
        boundary(16'h0404, 1, 4'd3, 0);
        chk("R9 user write ignored", 32'(pc), 32'(vec_of(3)));
        chk("R4 saved user mode", 32'(saved_priv), 0);
        rti = 1;
        cyc();
        chk("R10 back to user", 32'({priv, ie, pc}), 32'({1'b0, 1'b1, 16'h0404}));

        summary();
        $finish;
    end
endmodule